// File: doc/BRIEF.md
# Serial Transmitter with Holding Buffer and Flow Control

This block turns bytes written by a processor into an asynchronous serial bit stream. A single holding register sits in front of a shift engine, so software can queue the next character while the current one is still on the line. All bit timing comes from a 16X oversampling enable (`tick16`), one clock wide, supplied by a baud generator outside the block. Character width (5 to 8 bits), parity and stop length are set on configuration inputs. Each character captures them as it enters the shift engine, so a setting that changes mid-frame cannot corrupt that frame.

Pulse inputs enable, disable and reset the transmitter, start and end a line break, and assert or release the request-to-send output. Two optional handshakes are available. With clear-to-send gating on, a new character starts only while the synchronised `cts_n` is low. With automatic release on, `rts_n` returns high one bit time after a disabled transmitter has fully drained.

Top module: `uart_tx_fc`

## Requirements
- R1: After `rst`, `txd` and `rts_n` are high and `tx_rdy` and `tx_emt` are low.
- R2: `tx_rdy` is high only while the transmitter is enabled and the holding register is empty. An accepted write drops it on the next cycle. It rises again on the tick at which the character moves into the idle shift engine. A write while the holding register is full is dropped.
- R3: A frame is a low start bit, then `cfg_len`+5 data bits least significant bit first (unused upper bits ignored), then a parity bit if `cfg_par_en` is set, then a high stop period. The parity bit is the XOR of the data bits, inverted when `cfg_par_odd` is 1. Each start, data and parity bit lasts 16 ticks.
- R4: The stop period lasts 16+`cfg_stop` ticks for codes 0 to 14 and 32 ticks for code 15. For 5-bit characters it is never shorter than 24 ticks. A character waiting in the holding register starts on the tick that ends the stop period.
- R5: `tx_emt` is set when a stop period ends with the holding register empty, and it is cleared by an accepted write. While nothing is being sent, `txd` is high.
- R6: While the transmitter is disabled, writes are ignored: `tx_rdy` stays low and no frame appears on `txd`.
- R7: `cmd_disable` lets the frame in flight, and a character already held, finish. `cmd_reset` aborts at once: the next cycle shows `tx_rdy`, `tx_emt` and the shift engine idle, and `txd` is high a cycle later. The transmitter then stays off until `cmd_enable`.
- R8: After `cmd_break_on`, `txd` is held low continuously until `cmd_break_off`, and no new frame starts in between.
- R9: With `cfg_cts_en` set, a frame starts only while the synchronised `cts_n` is low. A rise of `cts_n`, or of `cfg_cts_en`, during a frame does not disturb that frame. The next character then waits, with `txd` high, until `cts_n` returns low.
- R10: `cmd_rts_on` drives `rts_n` low and `cmd_rts_off` drives it high. With `cfg_rts_auto` set, `rts_n` goes high 16 ticks after the transmitter is disabled and both the shift engine and the holding register are empty. It never does so while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16X bit-rate enable, one clock wide |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| cmd_enable | input | 1 | Enable the transmitter (pulse) |
| cmd_disable | input | 1 | Disable after draining (pulse) |
| cmd_reset | input | 1 | Abort and disable immediately (pulse) |
| cmd_break_on | input | 1 | Start a line break (pulse) |
| cmd_break_off | input | 1 | End a line break (pulse) |
| cmd_rts_on | input | 1 | Drive `rts_n` low (pulse) |
| cmd_rts_off | input | 1 | Drive `rts_n` high (pulse) |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop | input | 4 | Stop length code in sixteenths above one bit |
| cfg_cts_en | input | 1 | Gate frame starts on `cts_n` |
| cfg_rts_auto | input | 1 | Release `rts_n` automatically after drain while disabled |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| txd | output | 1 | Serial output, idle high |
| tx_rdy | output | 1 | Holding register can take a character |
| tx_emt | output | 1 | Transmitter fully drained |
| rts_n | output | 1 | Request to send, active low |

## Verification
The bench measures the time from one start edge to the next on back-to-back frames, over many stop codes and widths. A stop counter that is off by one, or that ignores the 5-bit floor, shifts that spacing by a multiple of the tick period. Clear-to-send is dropped in the middle of a frame. A design that checks it per bit would cut the frame short, and one that ignores it would let the queued character start early. The bench also watches the line after a reset command, during a break and while disabled. Any stray start bit there means an abort that did not stop, or a write that was not ignored. The automatic RTS release is timed against the drain point, which catches a release while still enabled or before a full bit time has passed.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int STOP_CODE_W = 4;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_START,
    SH_DATA,
    SH_PAR,
    SH_STOP
  } sh_state_t;

  typedef struct packed {
    logic [1:0]             len;
    logic                   par_en;
    logic                   par_odd;
    logic [STOP_CODE_W-1:0] stop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              accept_en,
  input  logic              take,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              accepted
);

  assign accepted = wr_en & accept_en & ~full;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (accepted) begin
      full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) begin
      data <= wr_data;
    end
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              go,
  input  logic [DATA_W-1:0] ld_data,
  input  frame_cfg_t        cfg,
  output logic              take,
  output logic              done,
  output logic              busy,
  output logic              line
);

  localparam int TW  = $clog2(OVERSAMPLE);
  localparam int BW  = $clog2(DATA_W);
  localparam int SLW = $clog2(2 * OVERSAMPLE + 1);
  localparam logic [STOP_CODE_W-1:0] CODE_MAX = '1;
  localparam logic [SLW-1:0] LEN_ONE  = SLW'(OVERSAMPLE);
  localparam logic [SLW-1:0] LEN_TWO  = SLW'(2 * OVERSAMPLE);
  localparam logic [SLW-1:0] LEN_MIN5 = SLW'(OVERSAMPLE + OVERSAMPLE / 2);

  sh_state_t         state;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [SLW-1:0]    scnt;
  logic [DATA_W-1:0] sreg;
  logic [BW-1:0]     last_idx;
  logic              par_en;
  logic              par_bit;
  logic [SLW-1:0]    slen;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked;
  logic [BW-1:0]     ld_last;
  logic [SLW-1:0]    ld_slen;
  logic              ld_par;
  logic              bit_end;
  logic              stop_last;

  // Frame parameters captured at load time
  always_comb begin
    ld_last = BW'(DATA_W - 4) + BW'(cfg.len);
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = (BW'(i) <= ld_last);
    end
    masked = ld_data & mask;
    ld_par = (^masked) ^ cfg.par_odd;
    if (cfg.stop == CODE_MAX) begin
      ld_slen = LEN_TWO;
    end else begin
      ld_slen = LEN_ONE + SLW'(cfg.stop);
    end
    if (cfg.len == 2'd0 && ld_slen < LEN_MIN5) begin
      ld_slen = LEN_MIN5;
    end
  end

  assign bit_end   = (tcnt == TW'(OVERSAMPLE - 1));
  assign stop_last = (state == SH_STOP) && (scnt == slen - 1'b1);
  assign take      = tick & go & ((state == SH_IDLE) | stop_last);
  assign done      = tick & stop_last;
  assign busy      = (state != SH_IDLE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state <= SH_IDLE;
      line  <= 1'b1;
      tcnt  <= '0;
      bidx  <= '0;
      scnt  <= '0;
    end else if (take) begin
      state <= SH_START;
      line  <= 1'b0;
      tcnt  <= '0;
      bidx  <= '0;
    end else if (tick) begin
      unique case (state)
        SH_START: begin
          if (bit_end) begin
            state <= SH_DATA;
            line  <= sreg[0];
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SH_DATA: begin
          if (bit_end) begin
            tcnt <= '0;
            if (bidx == last_idx) begin
              if (par_en) begin
                state <= SH_PAR;
                line  <= par_bit;
              end else begin
                state <= SH_STOP;
                line  <= 1'b1;
                scnt  <= '0;
              end
            end else begin
              bidx <= bidx + 1'b1;
              line <= sreg[1];
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SH_PAR: begin
          if (bit_end) begin
            state <= SH_STOP;
            line  <= 1'b1;
            scnt  <= '0;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SH_STOP: begin
          if (stop_last) begin
            state <= SH_IDLE;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Datapath without reset
  always_ff @(posedge clk) begin
    if (take) begin
      sreg     <= masked;
      last_idx <= ld_last;
      par_en   <= cfg.par_en;
      par_bit  <= ld_par;
      slen     <= ld_slen;
    end else if (tick && state == SH_DATA && bit_end) begin
      sreg <= sreg >> 1;
    end
  end

endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic assert_req,
  input  logic release_req,
  input  logic auto_en,
  input  logic drained,
  output logic rts_n
);

  localparam int TW = $clog2(OVERSAMPLE);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b1;
      cnt   <= '0;
    end else if (release_req) begin
      rts_n <= 1'b1;
      cnt   <= '0;
    end else if (assert_req) begin
      rts_n <= 1'b0;
      cnt   <= '0;
    end else if (auto_en && drained && !rts_n) begin
      if (tick) begin
        if (cnt == TW'(OVERSAMPLE - 1)) begin
          rts_n <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      cnt <= '0;
    end
  end

endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick16,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   cmd_enable,
  input  logic                   cmd_disable,
  input  logic                   cmd_reset,
  input  logic                   cmd_break_on,
  input  logic                   cmd_break_off,
  input  logic                   cmd_rts_on,
  input  logic                   cmd_rts_off,
  input  logic [1:0]             cfg_len,
  input  logic                   cfg_par_en,
  input  logic                   cfg_par_odd,
  input  logic [STOP_CODE_W-1:0] cfg_stop,
  input  logic                   cfg_cts_en,
  input  logic                   cfg_rts_auto,
  input  logic                   cts_n,
  output logic                   txd,
  output logic                   tx_rdy,
  output logic                   tx_emt,
  output logic                   rts_n
);

  logic [SYNC_STAGES-1:0] cts_pipe;
  logic                   cts_s;
  logic                   en_q;
  logic                   brk_q;
  logic                   emt_q;
  logic                   txd_q;
  logic                   hold_full;
  logic [DATA_W-1:0]      hold_data;
  logic                   hold_acc;
  logic                   sh_take;
  logic                   sh_done;
  logic                   sh_busy;
  logic                   sh_line;
  logic                   go;
  frame_cfg_t             fcfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_pipe <= '1;
    end else begin
      cts_pipe <= {cts_pipe[SYNC_STAGES-2:0], cts_n};
    end
  end
  assign cts_s = cts_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || cmd_reset || cmd_disable) begin
      en_q <= 1'b0;
    end else if (cmd_enable) begin
      en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_reset || cmd_break_off) begin
      brk_q <= 1'b0;
    end else if (cmd_break_on) begin
      brk_q <= 1'b1;
    end
  end

  assign fcfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop: cfg_stop};
  assign go   = hold_full & ~brk_q & (~cfg_cts_en | ~cts_s);

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .clr       (cmd_reset),
    .wr_en     (wr_en),
    .accept_en (en_q),
    .take      (sh_take),
    .wr_data   (wr_data),
    .full      (hold_full),
    .data      (hold_data),
    .accepted  (hold_acc)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clr     (cmd_reset),
    .tick    (tick16),
    .go      (go),
    .ld_data (hold_data),
    .cfg     (fcfg),
    .take    (sh_take),
    .done    (sh_done),
    .busy    (sh_busy),
    .line    (sh_line)
  );

  uart_tx_rts #(.OVERSAMPLE(OVERSAMPLE)) u_rts (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick16),
    .assert_req  (cmd_rts_on),
    .release_req (cmd_rts_off),
    .auto_en     (cfg_rts_auto),
    .drained     (~en_q & ~sh_busy & ~hold_full),
    .rts_n       (rts_n)
  );

  always_ff @(posedge clk) begin
    if (rst || cmd_reset || hold_acc) begin
      emt_q <= 1'b0;
    end else if (sh_done && !hold_full) begin
      emt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q <= 1'b1;
    end else begin
      txd_q <= brk_q ? 1'b0 : sh_line;
    end
  end

  assign txd    = txd_q;
  assign tx_emt = emt_q;
  assign tx_rdy = en_q & ~hold_full;

endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic cmd_disable,
  input logic cmd_reset,
  input logic cmd_rts_off,
  input logic tx_rdy,
  input logic tx_emt,
  input logic txd,
  input logic rts_n,
  input logic brk_q,
  input logic en_q,
  input logic busy,
  input logic full
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (txd && rts_n && !tx_rdy && !tx_emt));

  // R2
  rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_rdy) |=> !tx_rdy);

  // R5
  emt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_rdy) |=> !tx_emt);

  // R6
  dis_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_disable |=> !tx_rdy);

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (!tx_rdy && !tx_emt && !busy));

  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_q && $past(brk_q)) |-> !txd);

  // R10
  rts_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!rts_n && !cmd_rts_off && (en_q || busy || full)) |=> !rts_n);

endmodule

bind uart_tx_fc uart_tx_fc_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .cmd_disable (cmd_disable),
  .cmd_reset   (cmd_reset),
  .cmd_rts_off (cmd_rts_off),
  .tx_rdy      (tx_rdy),
  .tx_emt      (tx_emt),
  .txd         (txd),
  .rts_n       (rts_n),
  .brk_q       (brk_q),
  .en_q        (en_q),
  .busy        (sh_busy),
  .full        (hold_full)
);

// File: tb/uart_tx_fc_bench.sv
`timescale 1ns/1ps
module uart_tx_fc_bench;

  localparam int C_EN = 0, C_DIS = 1, C_RST = 2, C_BON = 3, C_BOFF = 4, C_RON = 5, C_ROFF = 6;
  localparam real BIT_NS = 320.0;

  logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmd_enable = 0, cmd_disable = 0, cmd_reset = 0, cmd_break_on = 0, cmd_break_off = 0;
  logic cmd_rts_on = 0, cmd_rts_off = 0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_cts_en = 0, cfg_rts_auto = 0, cts_n = 0;
  logic [3:0] cfg_stop = 4'd0;
  logic txd, tx_rdy, tx_emt, rts_n;

  int checks = 0, failures = 0, cyc = 0, low_cnt = 0;
  bit watch_on = 0, mon_on = 1;
  logic [7:0] exp_q[$];
  bit b2b_q[$];

  always #2.5 clk = ~clk;

  uart_tx_fc u_uart_tx_fc (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
    .cmd_break_on(cmd_break_on), .cmd_break_off(cmd_break_off),
    .cmd_rts_on(cmd_rts_on), .cmd_rts_off(cmd_rts_off),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_cts_en(cfg_cts_en), .cfg_rts_auto(cfg_rts_auto),
    .cts_n(cts_n), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt), .rts_n(rts_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_stop(input int code, input int len);
    int l;
    l = (code == 15) ? 32 : 16 + code;
    if (len == 0 && l < 24) l = 24;
    return l;
  endfunction

  function automatic bit exp_par(input logic [7:0] d, input int len, input bit odd);
    logic [7:0] m;
    m = d & 8'((9'd1 << (5 + len)) - 9'd1);
    return (^m) ^ odd;
  endfunction

  // 16X tick: one cycle in four
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div++;
      tick16 = (div % 4 == 0);
    end
  end

  always @(negedge clk) if (watch_on && !txd) low_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Line monitor: decodes frames by time and checks them against the queue
  initial begin
    realtime last_t = 0.0;
    forever begin
      realtime t0;
      logic [7:0] d;
      logic s_bit, p_bit, stp;
      int n;
      @(negedge txd);
      t0 = $realtime;
      n = 5 + int'(cfg_len);
      d = '0;
      p_bit = 1'b0;
      #161;
      s_bit = txd;
      for (int i = 0; i < n; i++) begin
        #(BIT_NS);
        d[i] = txd;
      end
      if (cfg_par_en) begin
        #(BIT_NS);
        p_bit = txd;
      end
      #(BIT_NS);
      stp = txd;
      if (mon_on) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected frame", int'(d), -1);
        end else begin
          logic [7:0] e;
          bit b;
          e = exp_q.pop_front() & 8'((9'd1 << n) - 9'd1);
          b = b2b_q.pop_front();
          chk(s_bit == 0, "R3 start bit", int'(s_bit), 0);
          chk(d == e, "R3 data bits", int'(d), int'(e));
          if (cfg_par_en)
            chk(p_bit == exp_par(e, int'(cfg_len), cfg_par_odd), "R3 parity", int'(p_bit),
                int'(exp_par(e, int'(cfg_len), cfg_par_odd)));
          chk(stp == 1, "R3 stop bit", int'(stp), 1);
          if (b) begin
            int want, got;
            want = ((1 + n + int'(cfg_par_en)) * 16 + exp_stop(int'(cfg_stop), int'(cfg_len))) * 20;
            got = int'(t0 - last_t);
            chk(got == want, "R4 start-to-start spacing ns", got, want);
          end
        end
      end
      last_t = t0;
    end
  end

  task automatic do_cmd(input int k);
    @(negedge clk);
    case (k)
      C_EN:    cmd_enable = 1;
      C_DIS:   cmd_disable = 1;
      C_RST:   cmd_reset = 1;
      C_BON:   cmd_break_on = 1;
      C_BOFF:  cmd_break_off = 1;
      C_RON:   cmd_rts_on = 1;
      default: cmd_rts_off = 1;
    endcase
    @(negedge clk);
    {cmd_enable, cmd_disable, cmd_reset, cmd_break_on, cmd_break_off, cmd_rts_on, cmd_rts_off} = '0;
  endtask

  task automatic write_char(input logic [7:0] d, input bit b2b, input bit push);
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
    wr_en = 1;
    wr_data = d;
    if (push) begin
      exp_q.push_back(d);
      b2b_q.push_back(b2b);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!tx_emt) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic watch(input int n);
    low_cnt = 0;
    watch_on = 1;
    repeat (n) @(negedge clk);
    watch_on = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(txd == 1, "R1 txd after reset", int'(txd), 1);
    chk(rts_n == 1, "R1 rts_n after reset", int'(rts_n), 1);
    chk(tx_rdy == 0, "R1 tx_rdy after reset", int'(tx_rdy), 0);
    chk(tx_emt == 0, "R1 tx_emt after reset", int'(tx_emt), 0);

    do_cmd(C_EN);
    chk(tx_rdy == 1, "R2 ready when enabled", int'(tx_rdy), 1);

    // Directed: R2 and R5
    write_char(8'hA5, 0, 1);
    chk(tx_rdy == 0, "R2 ready drops after write", int'(tx_rdy), 0);
    repeat (6) @(negedge clk);
    chk(tx_rdy == 1, "R2 ready back after transfer", int'(tx_rdy), 1);
    write_char(8'h3C, 1, 1);
    repeat (100) @(negedge clk);
    chk(tx_rdy == 0, "R2 ready low while held", int'(tx_rdy), 0);
    drain();
    chk(tx_emt == 1, "R5 empty after drain", int'(tx_emt), 1);
    chk(txd == 1, "R5 line idle high", int'(txd), 1);
    write_char(8'h01, 0, 1);
    chk(tx_emt == 0, "R5 empty cleared by write", int'(tx_emt), 0);
    drain();

    // Random batches with directed corners: R3, R4
    for (int b = 0; b < 12; b++) begin
      @(negedge clk);
      cfg_len = 2'($urandom % 4);
      cfg_par_en = 1'($urandom % 2);
      cfg_par_odd = 1'($urandom % 2);
      cfg_stop = 4'($urandom % 16);
      if (b == 0) begin cfg_len = 0; cfg_stop = 0; end
      if (b == 1) begin cfg_len = 0; cfg_stop = 15; end
      if (b == 2) begin cfg_len = 3; cfg_stop = 7; cfg_par_en = 1; cfg_par_odd = 1; end
      if (b == 3) begin cfg_len = 1; cfg_stop = 14; cfg_par_en = 1; cfg_par_odd = 0; end
      for (int i = 0; i < 4; i++) write_char(8'($urandom), i != 0, 1);
      drain();
    end
    @(negedge clk);
    cfg_len = 3; cfg_par_en = 0; cfg_stop = 0;

    // R9: CTS gating
    cfg_cts_en = 1;
    cts_n = 1;
    write_char(8'h5A, 0, 1);
    watch(900);
    chk(low_cnt == 0, "R9 no start while cts high", low_cnt, 0);
    chk(tx_emt == 0, "R9 char still pending", int'(tx_emt), 0);
    cts_n = 0;
    drain();
    write_char(8'hC3, 0, 1);
    write_char(8'h96, 0, 1);
    repeat (100) @(negedge clk);
    cts_n = 1;
    repeat (700) @(negedge clk);
    watch(800);
    chk(low_cnt == 0, "R9 next char waits for cts", low_cnt, 0);
    chk(tx_emt == 0, "R9 held char not sent", int'(tx_emt), 0);
    cts_n = 0;
    drain();
    cfg_cts_en = 0;
    write_char(8'h7E, 0, 1);
    repeat (100) @(negedge clk);
    cts_n = 1;
    cfg_cts_en = 1;
    drain();
    chk(tx_emt == 1, "R9 mode change mid-frame harmless", int'(tx_emt), 1);
    cfg_cts_en = 0;
    cts_n = 0;

    // R10: RTS control
    do_cmd(C_RON);
    chk(rts_n == 0, "R10 rts asserted by command", int'(rts_n), 0);
    cfg_rts_auto = 1;
    write_char(8'h11, 0, 1);
    drain();
    repeat (200) @(negedge clk);
    chk(rts_n == 0, "R10 rts kept while enabled", int'(rts_n), 0);
    write_char(8'h22, 0, 1);
    repeat (50) @(negedge clk);
    do_cmd(C_DIS);
    while (!tx_emt) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(rts_n == 0, "R10 rts held before one bit", int'(rts_n), 0);
    repeat (40) @(negedge clk);
    chk(rts_n == 1, "R10 rts released after one bit", int'(rts_n), 1);
    cfg_rts_auto = 0;
    do_cmd(C_RON);
    do_cmd(C_ROFF);
    chk(rts_n == 1, "R10 rts released by command", int'(rts_n), 1);

    // R6: writes while disabled
    @(negedge clk);
    wr_en = 1;
    wr_data = 8'hF0;
    @(negedge clk);
    wr_en = 0;
    chk(tx_rdy == 0, "R6 not ready while disabled", int'(tx_rdy), 0);
    chk(tx_emt == 1, "R6 empty unchanged", int'(tx_emt), 1);
    watch(900);
    chk(low_cnt == 0, "R6 no frame while disabled", low_cnt, 0);

    // R7: disable lets frame in flight and held char finish
    do_cmd(C_EN);
    write_char(8'h81, 0, 1);
    write_char(8'h42, 1, 1);
    repeat (100) @(negedge clk);
    do_cmd(C_DIS);
    drain();
    chk(exp_q.size() == 0, "R7 both chars sent after disable", exp_q.size(), 0);
    chk(tx_rdy == 0, "R7 not ready after disable", int'(tx_rdy), 0);

    // R7: reset command aborts
    do_cmd(C_EN);
    mon_on = 0;
    write_char(8'h00, 0, 0);
    repeat (200) @(negedge clk);
    do_cmd(C_RST);
    @(negedge clk);
    chk(txd == 1, "R7 line high after abort", int'(txd), 1);
    chk(tx_rdy == 0, "R7 disabled after abort", int'(tx_rdy), 0);
    chk(tx_emt == 0, "R7 empty cleared by abort", int'(tx_emt), 0);
    watch(900);
    chk(low_cnt == 0, "R7 nothing sent after abort", low_cnt, 0);

    // R8: break
    do_cmd(C_EN);
    do_cmd(C_BON);
    repeat (3) @(negedge clk);
    watch(300);
    chk(low_cnt >= 299, "R8 line low during break", low_cnt, 300);
    do_cmd(C_BOFF);
    repeat (3) @(negedge clk);
    chk(txd == 1, "R8 line high after break", int'(txd), 1);
    repeat (900) @(negedge clk);
    mon_on = 1;
    write_char(8'hE7, 0, 1);
    drain();
    chk(exp_q.size() == 0, "R3 all frames observed", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule